// File: doc/BRIEF.md
# Read Configuration Register Loader

This block watches the write cycles of an asynchronous memory bus and carries out a two-step command that replaces a 16-bit read configuration register. The bus strobes are active-low and asynchronous to the block's clock, so each one passes through a two-flop synchronizer. A bus write counts as completed at the first rising edge of any strobe, after chip enable and write enable have both been seen low. The command byte is sampled from a command input at that moment. In the confirming write, the new register value comes from the 16-bit address bus and not from the data lines.

The register sets how the read path behaves: whether reads are asynchronous or synchronous burst, the wait-state latency, the wrap order and the burst length. The block decodes these fields for the read datapath. It also reports whether a synchronous burst is allowed for the current read target. Status and identifier reads are never served as bursts. When the command finishes, or is abandoned, the block returns to read-array mode.

Top module: `rcfg_writer`

## Requirements
- R1: During and after reset the register holds 0xBFCF, the block is in read-array mode (`read_array_o`=1), and `cfg_err_o` is 0.
- R2: A completed bus write with command 0x60 in read-array mode enters setup (`read_array_o`=0). The next completed write with command 0x03 loads `addr_i[15:0]` into the register.
- R3: A bus write completes on the first rising edge among ADV#, CE# and WE#, once CE# and WE# have both been low. Address and command are sampled at that edge. Later rising edges are ignored until all three strobes are high again. Edges that rise in the same sample give one capture.
- R4: In setup, a completed write with any command other than 0x03 leaves the register unchanged and returns to read-array mode.
- R5: A confirm whose `addr_i[2:0]` is not 1, 2, 3 or 7 leaves the register unchanged and sets `cfg_err_o`. The next successful load clears `cfg_err_o`.
- R6: After the second write of a sequence, the block is in read-array mode.
- R7: The decoded outputs follow the register. Bit 15 = 1 selects asynchronous reads (`sync_mode_o`=0) and 0 selects synchronous burst. Bits 13:11 give `latency_o`. Bit 7 gives `wrap_order_o`. Bits 2:0 give the length: code 1 is 4 beats, 2 is 8, 3 is 16, and 7 is continuous (`burst_beats_o`=0, `burst_cont_o`=1).
- R8: `burst_ok_o` is 1 only when synchronous mode is selected and `tgt_ctl_i`=0. `tgt_ctl_i`=1 marks a status or identifier target.
- R9: In read-array mode, a completed write with any command other than 0x60 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_n_i | input | 1 | Address-valid strobe, active low, asynchronous |
| ce_n_i | input | 1 | Chip enable, active low, asynchronous |
| we_n_i | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | 16 | Address bus, which carries the new register value |
| cmd_i | input | 8 | Command byte of the bus write |
| tgt_ctl_i | input | 1 | Current read target is a status or identifier register |
| cfg_o | output | 16 | Register contents |
| sync_mode_o | output | 1 | Synchronous burst mode selected |
| latency_o | output | 3 | Latency count field |
| wrap_order_o | output | 1 | Burst order field |
| burst_beats_o | output | 5 | Burst length in beats (0 when continuous) |
| burst_cont_o | output | 1 | Continuous burst selected |
| burst_ok_o | output | 1 | Synchronous burst permitted for the current target |
| read_array_o | output | 1 | Block is in read-array mode |
| cfg_err_o | output | 1 | Last confirm carried a reserved length code |

## Verification
The assertions take for granted that address and command are stable from before the first strobe rise until several clocks after it. They also assume that CE# and WE# stay low for at least two clocks before any strobe rises, so that the synchronized levels open the cycle before the capturing edge arrives. The bench holds the strobes low for four clocks and changes the address only four clocks after the first rise. At that point the capture has already happened, so the swap checks that later edges are ignored.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  localparam int CFG_W = 16;
  localparam int CMD_W = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hBFCF;
  localparam logic [CMD_W-1:0] CMD_SETUP = 8'h60;
  localparam logic [CMD_W-1:0] CMD_CONFIRM = 8'h03;

  localparam int MODE_BIT = 15;
  localparam int LAT_LO = 11;
  localparam int LAT_W = 3;
  localparam int ORDER_BIT = 7;
  localparam int LEN_W = 3;
  localparam int BEATS_W = 5;

  localparam int N_STROBE = 3;
  localparam int IDX_ADV = 0;
  localparam int IDX_CE = 1;
  localparam int IDX_WE = 2;

  typedef enum logic {ST_ARRAY, ST_SETUP} rcw_state_e;

  function automatic logic len_valid(input logic [LEN_W-1:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3) || (code == 3'd7);
  endfunction

  function automatic logic [BEATS_W-1:0] beats_of(input logic [LEN_W-1:0] code);
    logic [BEATS_W-1:0] b;
    case (code)
      3'd1:    b = 5'd4;
      3'd2:    b = 5'd8;
      3'd3:    b = 5'd16;
      default: b = 5'd0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rcw_strobe_sync.sv
module rcw_strobe_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb_n_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  localparam int TOP = STAGES - 1;

  for (genvar g = 0; g < N; g++) begin : g_strb
    logic [STAGES-1:0] pipe_q;
    logic              last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '1;
        last_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], strb_n_i[g]};
        last_q <= pipe_q[TOP];
      end
    end
    assign lvl_o[g]  = pipe_q[TOP];
    assign rise_o[g] = pipe_q[TOP] & ~last_q;
  end
endmodule

// File: rtl/rcw_cmd_fsm.sv
module rcw_cmd_fsm
  import rcw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STROBE-1:0] lvl_i,
  input  logic [N_STROBE-1:0] rise_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [CFG_W-1:0]    addr_i,
  output logic                capture_o,
  output logic                in_setup_o,
  output logic                load_o,
  output logic                reject_o
);
  rcw_state_e state_q;
  logic       open_q;
  logic       done_q;
  logic       bus_low;
  logic       all_high;
  logic       confirm;

  assign bus_low  = ~lvl_i[IDX_CE] & ~lvl_i[IDX_WE];
  assign all_high = &lvl_i;
  assign capture_o = (|rise_i) & open_q & ~done_q;

  // one capture per bus cycle: block until every strobe is back high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else if (capture_o) begin
      done_q <= 1'b1;
    end else if (all_high) begin
      done_q <= 1'b0;
      open_q <= 1'b0;
    end else if (bus_low) begin
      open_q <= 1'b1;
    end
  end

  assign in_setup_o = (state_q == ST_SETUP);
  assign confirm    = capture_o & in_setup_o & (cmd_i == CMD_CONFIRM);
  assign load_o     = confirm & len_valid(addr_i[LEN_W-1:0]);
  assign reject_o   = confirm & ~len_valid(addr_i[LEN_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARRAY;
    end else if (capture_o) begin
      if (state_q == ST_SETUP) state_q <= ST_ARRAY;
      else if (cmd_i == CMD_SETUP) state_q <= ST_SETUP;
    end
  end
endmodule

// File: rtl/rcw_cfg_reg.sv
module rcw_cfg_reg
  import rcw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               reject_i,
  input  logic [CFG_W-1:0]   val_i,
  input  logic               tgt_ctl_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               err_o,
  output logic               sync_mode_o,
  output logic [LAT_W-1:0]   latency_o,
  output logic               wrap_order_o,
  output logic [BEATS_W-1:0] burst_beats_o,
  output logic               burst_cont_o,
  output logic               burst_ok_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else if (load_i) begin
      cfg_q <= val_i;
      err_q <= 1'b0;
    end else if (reject_i) begin
      err_q <= 1'b1;
    end
  end

  assign cfg_o         = cfg_q;
  assign err_o         = err_q;
  assign sync_mode_o   = ~cfg_q[MODE_BIT];
  assign latency_o     = cfg_q[LAT_LO +: LAT_W];
  assign wrap_order_o  = cfg_q[ORDER_BIT];
  assign burst_beats_o = beats_of(cfg_q[LEN_W-1:0]);
  assign burst_cont_o  = (cfg_q[LEN_W-1:0] == 3'd7);
  assign burst_ok_o    = sync_mode_o & ~tgt_ctl_i;
endmodule

// File: rtl/rcfg_writer.sv
module rcfg_writer
  import rcw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_n_i,
  input  logic               ce_n_i,
  input  logic               we_n_i,
  input  logic [15:0]        addr_i,
  input  logic [7:0]         cmd_i,
  input  logic               tgt_ctl_i,
  output logic [15:0]        cfg_o,
  output logic               sync_mode_o,
  output logic [2:0]         latency_o,
  output logic               wrap_order_o,
  output logic [4:0]         burst_beats_o,
  output logic               burst_cont_o,
  output logic               burst_ok_o,
  output logic               read_array_o,
  output logic               cfg_err_o
);
  logic [N_STROBE-1:0] strb_n_w;
  logic [N_STROBE-1:0] lvl_w;
  logic [N_STROBE-1:0] rise_w;
  logic                capture_w;
  logic                in_setup_w;
  logic                load_w;
  logic                reject_w;

  always_comb begin
    strb_n_w          = '1;
    strb_n_w[IDX_ADV] = adv_n_i;
    strb_n_w[IDX_CE]  = ce_n_i;
    strb_n_w[IDX_WE]  = we_n_i;
  end

  rcw_strobe_sync #(.N(N_STROBE), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb_n_i (strb_n_w),
    .lvl_o    (lvl_w),
    .rise_o   (rise_w)
  );

  rcw_cmd_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl_w),
    .rise_i     (rise_w),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .capture_o  (capture_w),
    .in_setup_o (in_setup_w),
    .load_o     (load_w),
    .reject_o   (reject_w)
  );

  rcw_cfg_reg u_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_w),
    .reject_i      (reject_w),
    .val_i         (addr_i),
    .tgt_ctl_i     (tgt_ctl_i),
    .cfg_o         (cfg_o),
    .err_o         (cfg_err_o),
    .sync_mode_o   (sync_mode_o),
    .latency_o     (latency_o),
    .wrap_order_o  (wrap_order_o),
    .burst_beats_o (burst_beats_o),
    .burst_cont_o  (burst_cont_o),
    .burst_ok_o    (burst_ok_o)
  );

  assign read_array_o = ~in_setup_w;
endmodule

// File: rtl/rcfg_writer_chk.sv
module rcfg_writer_chk
  import rcw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_o,
  input logic        cfg_err_o,
  input logic        read_array_o,
  input logic        burst_ok_o,
  input logic        tgt_ctl_i,
  input logic        capture_w,
  input logic        in_setup_w,
  input logic        load_w
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_state_r1: assert (cfg_o == CFG_RESET && read_array_o && !cfg_err_o);
    end
  end

  p_cfg_change_needs_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(load_w));

  p_one_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> !capture_w);

  p_back_to_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_w && in_setup_w) |=> read_array_o);

  p_err_from_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err_o) |-> $past(capture_w && in_setup_w));

  p_status_no_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_ctl_i |-> !burst_ok_o);

  p_async_no_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[MODE_BIT] |-> !burst_ok_o);

  p_idle_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_w && !in_setup_w) |=> $stable(cfg_o));
endmodule

bind rcfg_writer rcfg_writer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_o        (cfg_o),
  .cfg_err_o    (cfg_err_o),
  .read_array_o (read_array_o),
  .burst_ok_o   (burst_ok_o),
  .tgt_ctl_i    (tgt_ctl_i),
  .capture_w    (capture_w),
  .in_setup_w   (in_setup_w),
  .load_w       (load_w)
);

// File: tb/rcfg_writer_bench.sv
module rcfg_writer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b1;
  logic        adv_n = 1'b1, ce_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  cmd = '0;
  logic        tgt = 1'b0;

  logic [15:0] cfg;
  logic        sync_mode, wrap_order, burst_cont, burst_ok, read_array, cfg_err;
  logic [2:0]  latency;
  logic [4:0]  beats;

  rcfg_writer u_rcfg_writer (
    .clk(clk), .rst_n(rst_n), .adv_n_i(adv_n), .ce_n_i(ce_n), .we_n_i(we_n),
    .addr_i(addr), .cmd_i(cmd), .tgt_ctl_i(tgt), .cfg_o(cfg),
    .sync_mode_o(sync_mode), .latency_o(latency), .wrap_order_o(wrap_order),
    .burst_beats_o(beats), .burst_cont_o(burst_cont), .burst_ok_o(burst_ok),
    .read_array_o(read_array), .cfg_err_o(cfg_err)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: strobe history as a queue, newest first, {we,ce,adv}
  logic [2:0]  hist[$];
  logic [15:0] m_cfg;
  logic        m_err, m_setup, m_open, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{3'b111, 3'b111, 3'b111};
      m_cfg = 16'hBFCF; m_err = 0; m_setup = 0; m_open = 0; m_done = 0;
    end else begin
      logic [2:0] seen, prev;
      logic ev;
      seen = hist[1];
      prev = hist[2];
      ev = ((seen & ~prev) != 3'b000) && m_open && !m_done;
      if (ev) begin
        if (m_setup) begin
          m_setup = 0;
          if (cmd == 8'h03) begin
            if (addr[2:0] inside {3'd1, 3'd2, 3'd3, 3'd7}) begin
              m_cfg = addr; m_err = 0;
            end else m_err = 1;
          end
        end else if (cmd == 8'h60) m_setup = 1;
      end
      if (ev) m_done = 1;
      else if (seen == 3'b111) begin m_done = 0; m_open = 0; end
      else if (!seen[1] && !seen[2]) m_open = 1;
      hist.push_front({we_n, ce_n, adv_n});
      void'(hist.pop_back());
    end
  end

  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      int eb;
      eb = (m_cfg[2:0] >= 3'd1 && m_cfg[2:0] <= 3'd3) ? (2 ** (m_cfg[2:0] + 1)) : 0;
      chk("R3 cfg", cfg, m_cfg);
      chk("R5 err", {15'd0, cfg_err}, {15'd0, m_err});
      chk("R6 read_array", {15'd0, read_array}, {15'd0, !m_setup});
      chk("R7 sync", {15'd0, sync_mode}, {15'd0, !m_cfg[15]});
      chk("R7 latency", {13'd0, latency}, {13'd0, m_cfg[13:11]});
      chk("R7 order", {15'd0, wrap_order}, {15'd0, m_cfg[7]});
      chk("R7 beats", {11'd0, beats}, eb[15:0]);
      chk("R7 cont", {15'd0, burst_cont}, {15'd0, m_cfg[2:0] == 3'd7});
      chk("R8 burst_ok", {15'd0, burst_ok}, {15'd0, !m_cfg[15] && !tgt});
    end
  end

  // order: 0 WE first, 1 ADV first, 2 CE first, 3 all together
  task automatic bus_write(input logic [7:0] c, input logic [15:0] a,
                           input int order, input bit swap);
    @(negedge clk);
    addr = a; cmd = c; ce_n = 0; we_n = 0; adv_n = 0;
    repeat (4) @(negedge clk);
    case (order)
      0: we_n = 1;
      1: adv_n = 1;
      2: ce_n = 1;
      default: begin adv_n = 1; ce_n = 1; we_n = 1; end
    endcase
    repeat (4) @(negedge clk);
    if (swap) addr = ~a;
    adv_n = 1; ce_n = 1; we_n = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset cfg", cfg, 16'hBFCF);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cfg", cfg, 16'hBFCF);
    chk("R1 array", {15'd0, read_array}, 16'd1);
    chk("R1 err", {15'd0, cfg_err}, 16'd0);

    bus_write(8'h60, 16'h1234, 0, 0);
    chk("R2 in setup", {15'd0, read_array}, 16'd0);
    bus_write(8'h03, 16'h3A81, 0, 0);
    chk("R2 loaded", cfg, 16'h3A81);
    chk("R6 array", {15'd0, read_array}, 16'd1);
    chk("R7 beats4", {11'd0, beats}, 16'd4);
    chk("R8 ok", {15'd0, burst_ok}, 16'd1);
    tgt = 1;
    @(negedge clk);
    chk("R8 status target", {15'd0, burst_ok}, 16'd0);
    tgt = 0;

    bus_write(8'h60, 16'h0000, 0, 0);
    bus_write(8'hFF, 16'h0002, 0, 0);
    chk("R4 abort", cfg, 16'h3A81);
    chk("R4 array", {15'd0, read_array}, 16'd1);

    bus_write(8'h60, 16'h0000, 1, 0);
    bus_write(8'h03, 16'h0005, 0, 0);
    chk("R5 reserved", cfg, 16'h3A81);
    chk("R5 err set", {15'd0, cfg_err}, 16'd1);
    bus_write(8'h60, 16'h0000, 3, 0);
    bus_write(8'h03, 16'h4802, 3, 0);
    chk("R5 err cleared", {15'd0, cfg_err}, 16'd0);
    chk("R3 same-sample", cfg, 16'h4802);
    chk("R7 beats8", {11'd0, beats}, 16'd8);

    bus_write(8'h60, 16'h0000, 1, 1);
    bus_write(8'h03, 16'h0803, 1, 1);
    chk("R3 adv first", cfg, 16'h0803);
    chk("R7 beats16", {11'd0, beats}, 16'd16);

    bus_write(8'h60, 16'h0000, 2, 1);
    bus_write(8'h03, 16'h8007, 2, 1);
    chk("R3 ce first", cfg, 16'h8007);
    chk("R7 cont", {15'd0, burst_cont}, 16'd1);
    chk("R7 async", {15'd0, sync_mode}, 16'd0);

    bus_write(8'h03, 16'h1111, 0, 0);
    chk("R9 idle inert", cfg, 16'h8007);
    chk("R9 array", {15'd0, read_array}, 16'd1);

    for (int i = 0; i < 20; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      a[2:0] = (i % 4 == 3) ? 3'd7 : 3'((i % 4) + 1);
      if (i % 5 == 4) a[2:0] = 3'd6;
      tgt = i[0];
      bus_write(8'h60, 16'($urandom), i % 4, 0);
      bus_write(8'h03, a, (i + 1) % 4, i[1]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule